// File: doc/BRIEF.md
# Rotating-Priority Interrupt Controller Core

This block arbitrates eight interrupt request lines for a processor. Requests arrive already captured, as one-cycle set and clear pulses per line. The core holds them in a pending register and filters them through a mask register. A rotating priority scheme picks a winner. The winner is compared against the lines already being serviced. When the winner outranks everything in service, the core raises a registered interrupt output and presents an 8-bit vector. The vector is a programmable base with the line number in its low three bits.

Software drives the core through a byte-wide port with two addresses.

- On address 0, a write either starts a new initialisation sequence or issues a command. The commands cover the end-of-service variants, priority rotation, special masking, polling and the choice of which register a read returns.
- On address 1, writes walk the initialisation sequence. Once initialisation is done, they load the mask.

The processor side confirms that an interrupt was taken with a one-cycle acknowledge strobe. Software can also skip the interrupt output entirely and use a poll read.

Top module: `pic_core`

## Requirements
- R1: A write to address 0 with bit 4 set clears the pending, in-service and mask registers. It also clears the rotation offset, the vector base and all mode flags. It begins the initialisation sequence, and bit 0 of that write records whether a fourth word will follow.
- R2: During initialisation, the first write to address 1 sets the vector base to the data with bits 2:0 forced to zero. The second write ends the sequence unless a fourth word was requested. In the fourth word, bit 4 enables fully nested mode and bit 1 enables automatic end of service.
- R3: Outside initialisation, a write to address 1 loads the mask register, and a set mask bit keeps that line from winning. A read of address 1 returns the mask.
- R4: A write to address 0 with bit 4 clear and bit 3 set is a control word. Bit 2 arms a poll. When bit 1 is set, bit 0 picks the register returned by reads of address 0 (1 = in-service, 0 = pending). When bit 6 is set, bit 5 turns special mask mode on or off.
- R5: With rotation offset r, line (r+k) mod 8 has rank k, and the lowest rank wins. The vector is the base OR the winning line.
- R6: An interrupt is requested only when the winning pending rank is strictly lower than the best in-service rank. In special mask mode, masked lines are left out of the in-service set. In fully nested mode, line 2 is left out of it.
- R7: The interrupt output and vector are registered, so they follow a register change one clock later. The output is low when no request qualifies.
- R8: On acknowledge without automatic end of service, the winning line's in-service bit is set. With automatic end of service, the in-service set is untouched. If rotate-on-auto-end is set, the offset becomes winner+1. Rotate-on-auto-end is bit 7 of command codes 0 and 4. The pending bit is cleared only for lines whose `levelMode` bit is 0.
- R9: When a poll is armed, the next read of either address returns the winning line number in bits 2:0 and clears that line's pending and in-service bits. If nothing qualifies, the read returns 0. The poll is disarmed by that one read.
- R10: Other address-0 writes are decoded by bits 7:5. Code 1 clears the best-ranked in-service bit. Code 5 does the same and then rotates so that line becomes lowest. Code 3 clears the in-service bit named by bits 2:0. Code 7 does the same and rotates. Code 6 makes the line in bits 2:0 the lowest priority. Code 2 does nothing.
- R11: A read of address 0 without a poll returns the selected register and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register port write strobe |
| rdEn | input | 1 | Register port read strobe |
| addr | input | 1 | Register port address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data (combinational) |
| irqSet | input | 8 | Per-line pulse that sets a pending bit |
| irqClr | input | 8 | Per-line pulse that clears a pending bit |
| levelMode | input | 8 | Per-line level flag; level lines keep their pending bit on acknowledge |
| intAck | input | 1 | Acknowledge strobe |
| intOut | output | 1 | Registered interrupt request |
| intVector | output | 8 | Registered vector of the winning line |

## Verification
The resolver is tried under several pending patterns:
- two simultaneous requests, which shows that the lower rank wins;
- the same requests under a changed rotation offset, which shows that the offset, not the line number, sets the order;
- a request that is masked, which shows that the mask filter applies;
- requests set against a non-empty in-service set, which shows the strictly-lower comparison.

Special mask and fully nested mode each revisit an in-service set that blocks a request. In each case the bench shows that the block lifts only when the mode is on.

Poll reads are tried with a winner present and with none present. Each poll read is followed by a plain read, which shows that the poll consumed itself and cleared the right bits.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int PIC_LINES = 8;
  localparam int PIC_LW = $clog2(PIC_LINES);
  localparam int PIC_DW = 8;
  localparam int CASCADE_LINE = 2;

  typedef logic [PIC_LW-1:0] lineIdx_t;
  typedef logic [PIC_LW:0] rank_t;

  typedef enum logic [1:0] {
    STEP_NORMAL,
    STEP_BASE,
    STEP_WORD3,
    STEP_WORD4
  } initStep_e;

  typedef struct packed {
    logic     initClear;
    logic     maskLoad;
    logic     eoiBest;
    logic     eoiNamed;
    logic     rotateAfter;
    logic     setLowest;
    logic     pollRead;
    lineIdx_t cmdLine;
  } ctlStrobe_t;

  typedef struct packed {
    logic autoEoi;
    logic rotOnAutoEoi;
    logic fullyNested;
    logic specialMask;
  } ctlMode_t;

  // Rank of the best set bit with rotation offset rot; PIC_LINES when empty.
  function automatic rank_t bestRank(logic [PIC_LINES-1:0] bits, lineIdx_t rot);
    rank_t r;
    lineIdx_t idx;
    r = rank_t'(PIC_LINES);
    for (int k = PIC_LINES - 1; k >= 0; k--) begin
      idx = rot + lineIdx_t'(k);
      if (bits[idx]) r = rank_t'(k);
    end
    return r;
  endfunction
endpackage

// File: rtl/pic_ctrl.sv
module pic_ctrl
  import pic_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              addr,
  input  logic [PIC_DW-1:0] wrData,
  output ctlStrobe_t        strobe,
  output ctlMode_t          mode,
  output logic              readIsr,
  output logic              pollPend,
  output logic [PIC_DW-1:0] vecBase
);
  localparam logic [PIC_DW-1:0] BASE_KEEP = {PIC_DW{1'b1}} << PIC_LW;

  initStep_e         stepQ;
  logic              wantWord4Q;
  ctlMode_t          modeQ;
  logic              readIsrQ;
  logic              pollQ;
  logic [PIC_DW-1:0] baseQ;

  wire cmdWrite  = wrEn && !addr;
  wire dataWrite = wrEn && addr;
  wire [2:0] opCode = wrData[7:5];

  always_comb begin
    strobe = '0;
    strobe.cmdLine = wrData[PIC_LW-1:0];
    if (cmdWrite) begin
      if (wrData[4]) begin
        strobe.initClear = 1'b1;
      end else if (!wrData[3]) begin
        case (opCode)
          3'd1: strobe.eoiBest = 1'b1;
          3'd5: begin strobe.eoiBest = 1'b1; strobe.rotateAfter = 1'b1; end
          3'd3: strobe.eoiNamed = 1'b1;
          3'd7: begin strobe.eoiNamed = 1'b1; strobe.rotateAfter = 1'b1; end
          3'd6: strobe.setLowest = 1'b1;
          default: ;
        endcase
      end
    end
    strobe.maskLoad = dataWrite && (stepQ == STEP_NORMAL);
    strobe.pollRead = rdEn && pollQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepQ      <= STEP_NORMAL;
      wantWord4Q <= 1'b0;
      modeQ      <= '0;
      readIsrQ   <= 1'b0;
      pollQ      <= 1'b0;
      baseQ      <= '0;
    end else begin
      if (rdEn && pollQ) pollQ <= 1'b0;
      if (cmdWrite) begin
        if (wrData[4]) begin
          stepQ      <= STEP_BASE;
          wantWord4Q <= wrData[0];
          modeQ      <= '0;
          readIsrQ   <= 1'b0;
          pollQ      <= 1'b0;
          baseQ      <= '0;
        end else if (wrData[3]) begin
          if (wrData[2]) pollQ <= 1'b1;
          if (wrData[1]) readIsrQ <= wrData[0];
          if (wrData[6]) modeQ.specialMask <= wrData[5];
        end else if (opCode == 3'd0 || opCode == 3'd4) begin
          modeQ.rotOnAutoEoi <= wrData[7];
        end
      end else if (dataWrite) begin
        case (stepQ)
          STEP_BASE: begin
            baseQ <= wrData & BASE_KEEP;
            stepQ <= STEP_WORD3;
          end
          STEP_WORD3: stepQ <= wantWord4Q ? STEP_WORD4 : STEP_NORMAL;
          STEP_WORD4: begin
            modeQ.fullyNested <= wrData[4];
            modeQ.autoEoi     <= wrData[1];
            stepQ             <= STEP_NORMAL;
          end
          default: ;
        endcase
      end
    end
  end

  assign mode     = modeQ;
  assign readIsr  = readIsrQ;
  assign pollPend = pollQ;
  assign vecBase  = baseQ;
endmodule

// File: rtl/pic_datapath.sv
module pic_datapath
  import pic_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobe_t           strobe,
  input  ctlMode_t             mode,
  input  logic [PIC_DW-1:0]    wrData,
  input  logic [PIC_DW-1:0]    vecBase,
  input  logic [PIC_LINES-1:0] irqSet,
  input  logic [PIC_LINES-1:0] irqClr,
  input  logic [PIC_LINES-1:0] levelMode,
  input  logic                 ackIn,
  output logic [PIC_LINES-1:0] irrQ,
  output logic [PIC_LINES-1:0] isrQ,
  output logic [PIC_LINES-1:0] imrQ,
  output logic                 winValid,
  output lineIdx_t             winLine,
  output logic                 intOut,
  output logic [PIC_DW-1:0]    intVector
);
  lineIdx_t rotQ;
  logic [PIC_LINES-1:0] svcView, irrN, isrN, imrN;
  lineIdx_t rotN, eoiLine;
  rank_t pendRank, svcRank, eoiRank;

  always_comb begin
    svcView = isrQ;
    if (mode.specialMask) svcView = svcView & ~imrQ;
    if (mode.fullyNested) svcView[CASCADE_LINE] = 1'b0;
    pendRank = bestRank(irrQ & ~imrQ, rotQ);
    svcRank  = bestRank(svcView, rotQ);
    eoiRank  = bestRank(isrQ, rotQ);
    winValid = pendRank < svcRank;
    winLine  = rotQ + pendRank[PIC_LW-1:0];
    eoiLine  = rotQ + eoiRank[PIC_LW-1:0];
  end

  always_comb begin
    irrN = (irrQ | irqSet) & ~irqClr;
    isrN = isrQ;
    imrN = imrQ;
    rotN = rotQ;
    if (strobe.maskLoad) imrN = wrData[PIC_LINES-1:0];
    if (strobe.eoiBest && !eoiRank[PIC_LW]) begin
      isrN[eoiLine] = 1'b0;
      if (strobe.rotateAfter) rotN = eoiLine + lineIdx_t'(1);
    end
    if (strobe.eoiNamed) begin
      isrN[strobe.cmdLine] = 1'b0;
      if (strobe.rotateAfter) rotN = strobe.cmdLine + lineIdx_t'(1);
    end
    if (strobe.setLowest) rotN = strobe.cmdLine + lineIdx_t'(1);
    if (ackIn && winValid) begin
      if (mode.autoEoi) begin
        if (mode.rotOnAutoEoi) rotN = winLine + lineIdx_t'(1);
      end else begin
        isrN[winLine] = 1'b1;
      end
      if (!levelMode[winLine]) irrN[winLine] = 1'b0;
    end
    if (strobe.pollRead && winValid) begin
      irrN[winLine] = 1'b0;
      isrN[winLine] = 1'b0;
    end
    if (strobe.initClear) begin
      irrN = '0;
      isrN = '0;
      imrN = '0;
      rotN = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irrQ      <= '0;
      isrQ      <= '0;
      imrQ      <= '0;
      rotQ      <= '0;
      intOut    <= 1'b0;
      intVector <= '0;
    end else begin
      irrQ      <= irrN;
      isrQ      <= isrN;
      imrQ      <= imrN;
      rotQ      <= rotN;
      intOut    <= winValid;
      intVector <= vecBase | PIC_DW'(winLine);
    end
  end
endmodule

// File: rtl/pic_core.sv
module pic_core
  import pic_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic        addr,
  input  logic [7:0]  wrData,
  output logic [7:0]  rdData,
  input  logic [7:0]  irqSet,
  input  logic [7:0]  irqClr,
  input  logic [7:0]  levelMode,
  input  logic        intAck,
  output logic        intOut,
  output logic [7:0]  intVector
);
  ctlStrobe_t strobeBus;
  ctlMode_t   modeBus;
  logic readIsr, pollPend, winValid;
  logic [PIC_DW-1:0] vecBase;
  logic [PIC_LINES-1:0] irrQ, isrQ, imrQ;
  lineIdx_t winLine;

  pic_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .strobe(strobeBus), .mode(modeBus),
    .readIsr(readIsr), .pollPend(pollPend), .vecBase(vecBase)
  );

  pic_datapath dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobeBus), .mode(modeBus),
    .wrData(wrData), .vecBase(vecBase), .irqSet(irqSet), .irqClr(irqClr),
    .levelMode(levelMode), .ackIn(intAck), .irrQ(irrQ), .isrQ(isrQ),
    .imrQ(imrQ), .winValid(winValid), .winLine(winLine),
    .intOut(intOut), .intVector(intVector)
  );

  always_comb begin
    if (pollPend)     rdData = winValid ? PIC_DW'(winLine) : '0;
    else if (addr)    rdData = imrQ;
    else if (readIsr) rdData = isrQ;
    else              rdData = irrQ;
  end
endmodule

// File: rtl/pic_core_chk.sv
module pic_core_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic       rdEn,
  input logic       addr,
  input logic [7:0] wrData,
  input logic       intAck,
  input logic       intOut,
  input logic [7:0] irrQ,
  input logic [7:0] isrQ,
  input logic [7:0] imrQ,
  input logic       winValid,
  input logic [2:0] winLine,
  input logic       pollPend,
  input logic       autoEoi,
  input logic       maskLoad
);
  AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && !addr && wrData[4] |=> irrQ == 8'h00 && isrQ == 8'h00 && imrQ == 8'h00); // R1

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    maskLoad |=> imrQ == $past(wrData)); // R3

  AST_INT_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    intOut |-> $past((irrQ & ~imrQ) != 8'h00)); // R7

  AST_ACK_MARKS_SERVICE: assert property (@(posedge clk) disable iff (!rstN)
    intAck && winValid && !autoEoi && !wrEn && !rdEn |=> isrQ[$past(winLine)]); // R8

  AST_AUTO_EOI_KEEPS_SERVICE: assert property (@(posedge clk) disable iff (!rstN)
    intAck && autoEoi && !wrEn && !rdEn |=> isrQ == $past(isrQ)); // R8

  AST_POLL_ONE_SHOT: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && pollPend && !wrEn |=> !pollPend); // R9
endmodule

bind pic_core pic_core_chk chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
  .wrData(wrData), .intAck(intAck), .intOut(intOut), .irrQ(irrQ),
  .isrQ(isrQ), .imrQ(imrQ), .winValid(winValid), .winLine(winLine),
  .pollPend(pollPend), .autoEoi(modeBus.autoEoi),
  .maskLoad(strobeBus.maskLoad)
);

// File: tb/pic_core_tb.sv
module pic_core_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0, addr = 1'b0, intAck = 1'b0;
  logic [7:0] wrData = '0, irqSet = '0, irqClr = '0, levelMode = '0;
  logic [7:0] rdData, intVector;
  logic intOut;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_SET = 3'd2,
                         OP_ACK = 3'd3, OP_INT = 3'd4, OP_CLR = 3'd5;
  localparam int NV = 61;

  pic_core dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irqSet(irqSet), .irqClr(irqClr),
    .levelMode(levelMode), .intAck(intAck), .intOut(intOut),
    .intVector(intVector)
  );

  always #4 clk = ~clk;

  function automatic logic [24:0] mk(logic [2:0] op, logic a, logic [7:0] d,
                                     logic [8:0] e, logic [3:0] r);
    return {op, a, d, e, r};
  endfunction

  // {op, addr, data, expected {intOut, vector} or read byte, requirement}
  localparam logic [24:0] VEC [NV] = '{
    mk(OP_WR, 0, 8'h11, 9'h000, 1),   // R1 start init, fourth word wanted
    mk(OP_WR, 1, 8'h48, 9'h000, 2),   // R2 base 0x48
    mk(OP_WR, 1, 8'h00, 9'h000, 2),   // R2 word 3
    mk(OP_WR, 1, 8'h01, 9'h000, 2),   // R2 word 4, plain modes
    mk(OP_RD, 1, 8'h00, 9'h000, 3),   // R3 mask cleared
    mk(OP_RD, 0, 8'h00, 9'h000, 11),  // R11 pending empty
    mk(OP_INT,0, 8'h00, 9'h000, 7),   // R7 no request
    mk(OP_SET,0, 8'h28, 9'h000, 5),   // R5 lines 3 and 5
    mk(OP_INT,0, 8'h00, 9'h14B, 5),   // R5 line 3 wins
    mk(OP_RD, 0, 8'h00, 9'h028, 11),  // R11 pending readback
    mk(OP_WR, 1, 8'h08, 9'h000, 3),   // R3 mask line 3
    mk(OP_INT,0, 8'h00, 9'h14D, 3),   // R3 line 5 now wins
    mk(OP_RD, 1, 8'h00, 9'h008, 3),   // R3 mask readback
    mk(OP_WR, 1, 8'h00, 9'h000, 3),   // R3 unmask
    mk(OP_ACK,0, 8'h00, 9'h000, 8),   // R8 take line 3
    mk(OP_INT,0, 8'h00, 9'h000, 6),   // R6 line 5 blocked by 3
    mk(OP_WR, 0, 8'h0B, 9'h000, 4),   // R4 select in-service
    mk(OP_RD, 0, 8'h00, 9'h008, 8),   // R8 service bit 3
    mk(OP_SET,0, 8'h02, 9'h000, 6),   // R6 line 1
    mk(OP_INT,0, 8'h00, 9'h149, 6),   // R6 line 1 preempts
    mk(OP_ACK,0, 8'h00, 9'h000, 8),   // R8 take line 1
    mk(OP_RD, 0, 8'h00, 9'h00A, 8),   // R8 nested service
    mk(OP_WR, 0, 8'h20, 9'h000, 10),  // R10 best-ranked end
    mk(OP_RD, 0, 8'h00, 9'h008, 10),  // R10 line 1 retired
    mk(OP_INT,0, 8'h00, 9'h000, 6),   // R6 line 5 still blocked
    mk(OP_WR, 0, 8'h63, 9'h000, 10),  // R10 named end line 3
    mk(OP_RD, 0, 8'h00, 9'h000, 10),  // R10 service empty
    mk(OP_INT,0, 8'h00, 9'h14D, 10),  // R10 line 5 released
    mk(OP_WR, 0, 8'hC4, 9'h000, 10),  // R10 line 4 lowest
    mk(OP_SET,0, 8'h01, 9'h000, 5),   // R5 line 0 joins
    mk(OP_INT,0, 8'h00, 9'h14D, 5),   // R5 rotated order keeps 5
    mk(OP_ACK,0, 8'h00, 9'h000, 8),   // R8 take line 5
    mk(OP_INT,0, 8'h00, 9'h000, 6),   // R6 line 0 ranks below 5
    mk(OP_WR, 0, 8'hA0, 9'h000, 10),  // R10 end and rotate
    mk(OP_RD, 0, 8'h00, 9'h000, 10),  // R10 service empty
    mk(OP_INT,0, 8'h00, 9'h148, 10),  // R10 line 0 wins
    mk(OP_WR, 0, 8'h40, 9'h000, 10),  // R10 code 2 no effect
    mk(OP_INT,0, 8'h00, 9'h148, 10),  // R10 unchanged
    mk(OP_WR, 0, 8'hC7, 9'h000, 10),  // R10 line 7 lowest
    mk(OP_SET,0, 8'h10, 9'h000, 9),   // R9 line 4
    mk(OP_WR, 1, 8'h01, 9'h000, 3),   // R3 mask line 0
    mk(OP_INT,0, 8'h00, 9'h14C, 5),   // R5 line 4 wins
    mk(OP_WR, 0, 8'h0C, 9'h000, 4),   // R4 arm poll
    mk(OP_RD, 0, 8'h00, 9'h004, 9),   // R9 poll gives 4
    mk(OP_RD, 0, 8'h00, 9'h000, 9),   // R9 poll consumed
    mk(OP_WR, 0, 8'h0A, 9'h000, 4),   // R4 select pending
    mk(OP_RD, 0, 8'h00, 9'h001, 9),   // R9 line 4 cleared
    mk(OP_INT,0, 8'h00, 9'h000, 3),   // R3 masked line idle
    mk(OP_WR, 0, 8'h0C, 9'h000, 4),   // R4 arm poll
    mk(OP_RD, 1, 8'h00, 9'h000, 9),   // R9 empty poll gives 0
    mk(OP_RD, 1, 8'h00, 9'h001, 11),  // R11 mask after poll
    mk(OP_WR, 1, 8'h00, 9'h000, 3),   // R3 unmask
    mk(OP_INT,0, 8'h00, 9'h148, 5),   // R5 line 0
    mk(OP_ACK,0, 8'h00, 9'h000, 8),   // R8 take line 0
    mk(OP_SET,0, 8'h04, 9'h000, 6),   // R6 line 2
    mk(OP_INT,0, 8'h00, 9'h000, 6),   // R6 blocked by 0
    mk(OP_WR, 1, 8'h01, 9'h000, 3),   // R3 mask line 0
    mk(OP_WR, 0, 8'h68, 9'h000, 6),   // R6 special mask on
    mk(OP_INT,0, 8'h00, 9'h14A, 6),   // R6 line 2 released
    mk(OP_WR, 0, 8'h48, 9'h000, 6),   // R6 special mask off
    mk(OP_INT,0, 8'h00, 9'h000, 6)    // R6 blocked again
  };

  task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doOp(input logic [2:0] op, input logic a, input logic [7:0] d,
                      input logic [8:0] e, input string tag);
    @(negedge clk);
    case (op)
      OP_WR:  begin wrEn = 1'b1; addr = a; wrData = d; end
      OP_RD:  begin rdEn = 1'b1; addr = a; #1; check(tag, {1'b0, rdData}, e); end
      OP_SET: irqSet = d;
      OP_CLR: irqClr = d;
      OP_ACK: intAck = 1'b1;
      default: begin #1; check(tag, {intOut, intOut ? intVector : 8'h00}, e); end
    endcase
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0; intAck = 1'b0; irqSet = '0; irqClr = '0;
    @(negedge clk);
  endtask

  task automatic applyReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      finish();
    end
  end

  initial begin
    applyReset();
    check("R7 reset intOut", {8'h00, intOut}, 9'h000);
    doOp(OP_RD, 1, 8'h00, 9'h000, "R1 reset mask");

    for (int i = 0; i < NV; i++)
      doOp(VEC[i][24:22], VEC[i][21], VEC[i][20:13], VEC[i][12:4],
           $sformatf("R%0d table %0d", VEC[i][3:0], i));

    // Reset mid-run clears all visible state
    applyReset();
    check("R7 reset drops intOut", {8'h00, intOut}, 9'h000);
    doOp(OP_RD, 0, 8'h00, 9'h000, "R11 pending after reset");
    doOp(OP_RD, 1, 8'h00, 9'h000, "R1 mask after reset");

    // R2: no fourth word; third write ends the sequence
    doOp(OP_WR, 0, 8'h10, 9'h000, "R2");
    doOp(OP_WR, 1, 8'h87, 9'h000, "R2");
    doOp(OP_WR, 1, 8'h00, 9'h000, "R2");
    doOp(OP_WR, 1, 8'hFE, 9'h000, "R2");
    doOp(OP_RD, 1, 8'h00, 9'h0FE, "R2 mask after short init");
    doOp(OP_WR, 1, 8'h00, 9'h000, "R3");
    doOp(OP_SET, 0, 8'h08, 9'h000, "R5");
    doOp(OP_INT, 0, 8'h00, 9'h183, "R2 base low bits cleared");

    // R8: automatic end of service with rotation
    doOp(OP_WR, 0, 8'h11, 9'h000, "R1");
    doOp(OP_WR, 1, 8'h23, 9'h000, "R2");
    doOp(OP_WR, 1, 8'h00, 9'h000, "R2");
    doOp(OP_WR, 1, 8'h02, 9'h000, "R2");
    doOp(OP_WR, 0, 8'h80, 9'h000, "R8");
    doOp(OP_SET, 0, 8'h40, 9'h000, "R8");
    doOp(OP_INT, 0, 8'h00, 9'h126, "R8 line 6 request");
    doOp(OP_ACK, 0, 8'h00, 9'h000, "R8");
    doOp(OP_WR, 0, 8'h0B, 9'h000, "R4");
    doOp(OP_RD, 0, 8'h00, 9'h000, "R8 auto end keeps service empty");
    doOp(OP_SET, 0, 8'h81, 9'h000, "R8");
    doOp(OP_INT, 0, 8'h00, 9'h127, "R8 rotation makes line 7 first");

    // R6: fully nested mode ignores line 2 in service
    doOp(OP_WR, 0, 8'h11, 9'h000, "R1");
    doOp(OP_WR, 1, 8'h30, 9'h000, "R2");
    doOp(OP_WR, 1, 8'h00, 9'h000, "R2");
    doOp(OP_WR, 1, 8'h10, 9'h000, "R2");
    doOp(OP_SET, 0, 8'h04, 9'h000, "R6");
    doOp(OP_ACK, 0, 8'h00, 9'h000, "R8");
    doOp(OP_SET, 0, 8'h04, 9'h000, "R6");
    doOp(OP_INT, 0, 8'h00, 9'h132, "R6 fully nested re-request");

    // R8: level line keeps its pending bit on acknowledge
    levelMode = 8'h02;
    doOp(OP_WR, 0, 8'h10, 9'h000, "R1");
    doOp(OP_WR, 1, 8'h30, 9'h000, "R2");
    doOp(OP_WR, 1, 8'h00, 9'h000, "R2");
    doOp(OP_SET, 0, 8'h02, 9'h000, "R8");
    doOp(OP_ACK, 0, 8'h00, 9'h000, "R8");
    doOp(OP_RD, 0, 8'h00, 9'h002, "R8 level pending kept");
    doOp(OP_CLR, 0, 8'h02, 9'h000, "R8");
    doOp(OP_RD, 0, 8'h00, 9'h000, "R8 level pending dropped");
    levelMode = 8'h00;

    finished = 1'b1;
    finish();
  end
endmodule